// File: doc/BRIEF.md
# Precision-Mode MAC Array Sequencer

This block sequences a tensor core of multiply-accumulate units across one output tile. Software sets three configuration registers through a simple register port: the precision mode, the accumulation depth and the tile size. A start pulse launches the tile. The sequencer then takes operand beats from the input streamers under a valid/ready handshake. After a set number of beats it raises an output-valid strobe toward the quantization stage. When the whole tile has been produced it pulses done.

The 2-bit precision mode sets three things: how many accepted beats make one accumulation step, which input stream channels are active, and whether the floating-point datapath units run. Those units are the exponent alignment stage, the wide adder and the early-accumulation stage. In integer mode only one stream channel runs and the floating-point units stay gated. The mode code itself is driven to the datapath at all times. The arithmetic is outside this block.

Top module: `mxp_mac_ctrl`

## Requirements
- R1: After reset the sequencer is idle. busy, done, out_valid, acc_clear and in_ready are low. chan_en and fp_unit_en are all zero. The stored mode is 00, the stored depth is 1 and the stored tile size is 1.
- R2: The register address selects the register. Address 0 holds the mode in bits [1:0] and reads back busy in bit 8 (read-only). Address 1 holds the depth in bits [DEPTH_W-1:0]. Address 2 holds the tile size in bits [TILE_W-1:0]. Address 3 reads as zero. Read data is combinational from cfg_addr.
- R3: A register write is ignored while busy is high. The stored value, and mode_out, keep their old values.
- R4: Beats per step are 8 for mode 00 (INT8), 2 for mode 01 (FP8), 2 for mode 10 (FP6) and 1 for mode 11 (FP4). out_valid is high for one cycle, in the cycle after accepted beat number k·depth·beats_per_step of the tile, for k = 1 to the tile size.
- R5: A beat is accepted only in a cycle with in_valid and in_ready both high. in_ready is high only while running and out_ready is high. All other cycles leave the counters unchanged.
- R6: fp_unit_en (bit 0 alignment, bit 1 wide adder, bit 2 early accumulation) is 3'b111 while running in modes 01, 10 and 11. It is 3'b000 in mode 00 and whenever the sequencer is not running.
- R7: While running, chan_en is 4'b0001 in mode 00 and 4'b1111 in the other modes. It is zero when not running.
- R8: done is high for exactly one cycle, the same cycle as the last out_valid of the tile. busy is low in the next cycle.
- R9: A stored depth or tile size of zero acts as one. The stored value still reads back as zero.
- R10: start is ignored while busy. acc_clear is high in every cycle in which out_valid is high.
- R11: mode_out always equals the stored mode register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address, for both write and read |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register read data |
| start | input | 1 | Launches a tile when idle |
| busy | output | 1 | High from start until the cycle after done |
| done | output | 1 | One-cycle tile-complete pulse |
| in_valid | input | 1 | Operand streamers have a beat |
| in_ready | output | 1 | Sequencer accepts a beat |
| out_ready | input | 1 | Quantization stage can take results |
| out_valid | output | 1 | One accumulation result is complete |
| acc_clear | output | 1 | Clear the accumulators for the next element |
| mode_out | output | 2 | Precision mode code to the datapath |
| chan_en | output | NCH | Active input stream channels |
| fp_unit_en | output | 3 | Floating-point unit enables |

## Verification
The bench attacks beat counting under stalls on both sides. A design that counted beats when in_valid was low, or while out_ready was low, would raise out_valid after too few accepted beats. It also checks all four mode codes, because swapping the step lengths of FP4 and the FP8/FP6 codes would move every strobe. In mid-run it writes a register and pulses start. A design that honoured either one would change the mode or restart the counts and spoil the expected strobe positions. Zero depth and zero tile size are run as well: a design that took zero literally would never strobe or would never finish.

// File: rtl/mxp_ctrl_pkg.sv
`timescale 1ns/1ps
package mxp_ctrl_pkg;

  typedef enum logic [1:0] {
    PM_INT8 = 2'b00,
    PM_FP8  = 2'b01,
    PM_FP6  = 2'b10,
    PM_FP4  = 2'b11
  } prec_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;

  localparam logic [1:0] RA_MODE  = 2'd0;
  localparam logic [1:0] RA_DEPTH = 2'd1;
  localparam logic [1:0] RA_TILE  = 2'd2;
  localparam int BUSY_BIT = 8;

  // Accepted operand beats that form one accumulation step
  function automatic logic [3:0] beats_per_step(input logic [1:0] mode);
    case (mode)
      PM_INT8: return 4'd8;
      PM_FP8:  return 4'd2;
      PM_FP6:  return 4'd2;
      default: return 4'd1;
    endcase
  endfunction

endpackage

// File: rtl/mxp_cfg_regs.sv
`timescale 1ns/1ps
module mxp_cfg_regs
  import mxp_ctrl_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DEPTH_W = 8,
  parameter int TILE_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               lock,
  output logic [1:0]         mode,
  output logic [DEPTH_W-1:0] depth,
  output logic [TILE_W-1:0]  tile,
  output logic [DATA_W-1:0]  rdata
);

  logic wr_take;
  assign wr_take = wr_en && !lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= 2'b00;
      depth <= DEPTH_W'(1);
      tile  <= TILE_W'(1);
    end else if (wr_take) begin
      case (addr)
        RA_MODE:  mode  <= wdata[1:0];
        RA_DEPTH: depth <= wdata[DEPTH_W-1:0];
        RA_TILE:  tile  <= wdata[TILE_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RA_MODE: begin
        rdata[1:0]     = mode;
        rdata[BUSY_BIT] = lock;
      end
      RA_DEPTH: rdata[DEPTH_W-1:0] = depth;
      RA_TILE:  rdata[TILE_W-1:0]  = tile;
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/mxp_seq_fsm.sv
`timescale 1ns/1ps
module mxp_seq_fsm
  import mxp_ctrl_pkg::*;
#(
  parameter int DEPTH_W = 8,
  parameter int TILE_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         mode,
  input  logic [DEPTH_W-1:0] depth,
  input  logic [TILE_W-1:0]  tile,
  input  logic               in_valid,
  input  logic               out_ready,
  output logic               running,
  output logic               in_ready,
  output logic               out_valid,
  output logic               done,
  output logic               busy
);

  localparam int BEAT_W = DEPTH_W + 4;

  function automatic logic [DEPTH_W-1:0] depth_eff(input logic [DEPTH_W-1:0] d);
    return (d == '0) ? DEPTH_W'(1) : d;
  endfunction

  function automatic logic [TILE_W-1:0] tile_eff(input logic [TILE_W-1:0] t);
    return (t == '0) ? TILE_W'(1) : t;
  endfunction

  seq_state_e        state;
  logic [BEAT_W-1:0] beat_cnt;
  logic [BEAT_W-1:0] beat_target;
  logic [TILE_W-1:0] out_cnt;
  logic              beat_take;
  logic              step_last;
  logic              tile_last;

  assign running     = (state == ST_RUN);
  assign in_ready    = running && out_ready;
  assign beat_take   = in_valid && in_ready;
  assign beat_target = BEAT_W'(depth_eff(depth)) * BEAT_W'(beats_per_step(mode));
  assign step_last   = beat_take && (beat_cnt == beat_target - BEAT_W'(1));
  assign tile_last   = step_last && (out_cnt == tile_eff(tile) - TILE_W'(1));
  assign done        = (state == ST_DONE);
  assign busy        = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      beat_cnt  <= '0;
      out_cnt   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= step_last;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_RUN;
            beat_cnt <= '0;
            out_cnt  <= '0;
          end
        end
        ST_RUN: begin
          if (beat_take) begin
            if (step_last) begin
              beat_cnt <= '0;
              out_cnt  <= out_cnt + TILE_W'(1);
              if (tile_last) state <= ST_DONE;
            end else begin
              beat_cnt <= beat_cnt + BEAT_W'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mxp_unit_gate.sv
`timescale 1ns/1ps
module mxp_unit_gate
  import mxp_ctrl_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           running,
  input  logic [1:0]     mode,
  output logic [NCH-1:0] chan_en,
  output logic [2:0]     fp_unit_en
);

  logic fp_active;
  assign fp_active = running && (mode != PM_INT8);

  assign chan_en[0] = running;
  for (genvar ch = 1; ch < NCH; ch++) begin : g_chan
    assign chan_en[ch] = fp_active;
  end

  // bit 0 alignment, bit 1 wide adder, bit 2 early accumulation
  assign fp_unit_en = {3{fp_active}};

endmodule

// File: rtl/mxp_mac_ctrl.sv
`timescale 1ns/1ps
module mxp_mac_ctrl #(
  parameter int DATA_W  = 32,
  parameter int DEPTH_W = 8,
  parameter int TILE_W  = 12,
  parameter int NCH     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              start,
  output logic              busy,
  output logic              done,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              out_ready,
  output logic              out_valid,
  output logic              acc_clear,
  output logic [1:0]        mode_out,
  output logic [NCH-1:0]    chan_en,
  output logic [2:0]        fp_unit_en
);

  logic [1:0]         cfg_mode;
  logic [DEPTH_W-1:0] cfg_depth;
  logic [TILE_W-1:0]  cfg_tile;
  logic               running;

  mxp_cfg_regs #(.DATA_W(DATA_W), .DEPTH_W(DEPTH_W), .TILE_W(TILE_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cfg_wr_en),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .lock  (busy),
    .mode  (cfg_mode),
    .depth (cfg_depth),
    .tile  (cfg_tile),
    .rdata (cfg_rdata)
  );

  mxp_seq_fsm #(.DEPTH_W(DEPTH_W), .TILE_W(TILE_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode      (cfg_mode),
    .depth     (cfg_depth),
    .tile      (cfg_tile),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .running   (running),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .done      (done),
    .busy      (busy)
  );

  mxp_unit_gate #(.NCH(NCH)) u_gate (
    .running    (running),
    .mode       (cfg_mode),
    .chan_en    (chan_en),
    .fp_unit_en (fp_unit_en)
  );

  assign acc_clear = out_valid;
  assign mode_out  = cfg_mode;

endmodule

// File: rtl/mxp_mac_ctrl_chk.sv
`timescale 1ns/1ps
module mxp_mac_ctrl_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic           in_valid,
  input logic           in_ready,
  input logic           out_ready,
  input logic           out_valid,
  input logic [1:0]     mode_out,
  input logic [NCH-1:0] chan_en,
  input logic [2:0]     fp_unit_en
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R8
  AST_ACCEPT_WHEN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (busy && !done)); // R5
  AST_READY_NEEDS_SINK: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> out_ready); // R5
  AST_STROBE_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && in_ready)); // R4
  AST_INT8_UNITS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_out == 2'b00) |-> (fp_unit_en == 3'b000)); // R6
  AST_INT8_ONE_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_out == 2'b00) |-> ($countones(chan_en) <= 1)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (chan_en == '0 && fp_unit_en == 3'b000 && !in_ready)); // R7
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode_out)); // R3

endmodule

bind mxp_mac_ctrl mxp_mac_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_ready  (out_ready),
  .out_valid  (out_valid),
  .mode_out   (mode_out),
  .chan_en    (chan_en),
  .fp_unit_en (fp_unit_en)
);

// File: tb/mxp_mac_ctrl_bench.sv
`timescale 1ns/1ps
module mxp_mac_ctrl_bench;

  localparam int DATA_W  = 32;
  localparam int DEPTH_W = 8;
  localparam int TILE_W  = 12;
  localparam int NCH     = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_wr_en = 1'b0;
  logic [1:0]        cfg_addr = 2'd0;
  logic [DATA_W-1:0] cfg_wdata = '0;
  logic [DATA_W-1:0] cfg_rdata;
  logic              start = 1'b0;
  logic              busy, done;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic              out_ready = 1'b0;
  logic              out_valid, acc_clear;
  logic [1:0]        mode_out;
  logic [NCH-1:0]    chan_en;
  logic [2:0]        fp_unit_en;

  int checks = 0;
  int errors = 0;
  int beats = 0;
  int exp_q[$];
  bit done_flag = 0;
  bit finished = 0;
  bit mon_on = 0;
  int cur_mode = 0;

  always #2 clk = ~clk;

  mxp_mac_ctrl #(.DATA_W(DATA_W), .DEPTH_W(DEPTH_W), .TILE_W(TILE_W), .NCH(NCH)) u_mxp_mac_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .start(start), .busy(busy),
    .done(done), .in_valid(in_valid), .in_ready(in_ready), .out_ready(out_ready),
    .out_valid(out_valid), .acc_clear(acc_clear), .mode_out(mode_out),
    .chan_en(chan_en), .fp_unit_en(fp_unit_en)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int step_beats(input int m);
    if (m == 0) return 8;
    if (m == 3) return 1;
    return 2;
  endfunction

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    cfg_wr_en = 1'b1; cfg_addr = 2'(a); cfg_wdata = DATA_W'(d);
    @(posedge clk); #1;
    cfg_wr_en = 1'b0; cfg_addr = 2'd0;
  endtask

  task automatic rd(input int a, output int v);
    @(posedge clk); #1;
    cfg_addr = 2'(a);
    @(negedge clk);
    v = int'(cfg_rdata);
    #1 cfg_addr = 2'd0;
  endtask

  // Monitor: pops expected strobe positions, counted in accepted beats
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4", "unexpected out_valid at beat", beats, -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(beats == e, "R4", "strobe beat position", beats, e);
        end
        check(acc_clear == 1'b1, "R10", "acc_clear with out_valid", int'(acc_clear), 1);
      end
      if (in_ready && !out_ready)
        check(1'b0, "R5", "in_ready while out_ready low", 1, 0);
      if (in_valid && in_ready) beats++;
      if (busy && !done) begin
        check(int'(chan_en) == ((cur_mode == 0) ? 1 : 15), "R7", "chan_en in run",
              int'(chan_en), (cur_mode == 0) ? 1 : 15);
        check(int'(fp_unit_en) == ((cur_mode == 0) ? 0 : 7), "R6", "fp_unit_en in run",
              int'(fp_unit_en), (cur_mode == 0) ? 0 : 7);
        if (cfg_addr == 2'd0 && !cfg_wr_en)
          check(cfg_rdata[8] == 1'b1, "R2", "busy bit read", int'(cfg_rdata[8]), 1);
      end
      if (done) begin
        check(exp_q.size() == 0, "R8", "outputs left at done", exp_q.size(), 0);
        done_flag = 1;
      end
    end
  end

  // Driver: programs a tile, pushes the expected strobes, streams beats
  task automatic run_tile(input int mode, input int depth, input int tile,
                          input int vgap, input int rgap, input bit meddle);
    int d, t, c, cyc, v;
    wr(0, mode); wr(1, depth); wr(2, tile);
    d = (depth == 0) ? 1 : depth;
    t = (tile == 0) ? 1 : tile;
    c = step_beats(mode);
    cur_mode = mode;
    for (int k = 1; k <= t; k++) exp_q.push_back(k * d * c);
    @(posedge clk); #1;
    beats = 0; done_flag = 0; mon_on = 1;
    start = 1'b1;
    cyc = 0;
    while (!done_flag) begin
      @(posedge clk); #1;
      start = 1'b0; cfg_wr_en = 1'b0; cfg_addr = 2'd0;
      in_valid  = (vgap > 0) ? ((cyc % vgap) != 0) : 1'b1;
      out_ready = (rgap > 0) ? ((cyc % rgap) != 0) : 1'b1;
      if (meddle && cyc == 3) begin
        cfg_wr_en = 1'b1; cfg_wdata = DATA_W'(mode ^ 3);  // R3 mid-run write
      end
      if (meddle && cyc == 5) start = 1'b1;               // R10 mid-run start
      cyc++;
    end
    #1 in_valid = 1'b0; start = 1'b0; cfg_wr_en = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R8", "busy after done", int'(busy), 0);
    check(exp_q.size() == 0, "R4", "missing strobes", exp_q.size(), 0);
    mon_on = 0;
    exp_q.delete();
    rd(0, v);
    check((v & 3) == mode, "R3", "mode after run", v & 3, mode);
    check(int'(mode_out) == mode, "R11", "mode_out after run", int'(mode_out), mode);
  endtask

  initial begin
    int v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(busy == 0 && done == 0, "R1", "busy/done in reset", int'({busy, done}), 0);
    check(out_valid == 0 && acc_clear == 0 && in_ready == 0, "R1", "strobes in reset",
          int'({out_valid, acc_clear, in_ready}), 0);
    check(chan_en == '0 && fp_unit_en == '0, "R1", "enables in reset",
          int'({chan_en, fp_unit_en}), 0);
    check(mode_out == 2'b00, "R1", "mode in reset", int'(mode_out), 0);
    #1 rst_n = 1'b1;
    rd(1, v); check(v == 1, "R1", "depth reset value", v, 1);
    rd(2, v); check(v == 1, "R1", "tile reset value", v, 1);

    wr(0, 2); wr(1, 5); wr(2, 7);
    rd(0, v); check(v == 2, "R2", "mode readback, busy bit clear", v, 2);
    rd(1, v); check(v == 5, "R2", "depth readback", v, 5);
    rd(2, v); check(v == 7, "R2", "tile readback", v, 7);
    rd(3, v); check(v == 0, "R2", "address 3 reads zero", v, 0);
    check(mode_out == 2'b10, "R11", "mode_out follows register", int'(mode_out), 2);

    run_tile(0, 3, 2, 0, 0, 0);   // INT8 steady
    run_tile(1, 4, 3, 3, 0, 0);   // FP8 with input gaps (R5)
    run_tile(2, 2, 3, 0, 4, 0);   // FP6 with sink backpressure (R5)
    run_tile(3, 3, 5, 2, 3, 1);   // FP4 with both stalls, mid-run write and start
    run_tile(0, 1, 1, 0, 0, 1);   // INT8 single step, mid-run write and start
    run_tile(3, 0, 0, 0, 0, 0);   // R9 zero depth and tile act as one
    rd(1, v); check(v == 0, "R9", "zero depth reads back", v, 0);
    rd(2, v); check(v == 0, "R9", "zero tile reads back", v, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule